// File: doc/BRIEF.md
# Vector Address Set-Bit Sequencer

The sequencer takes one vector-address byte, where each set bit marks a byte position that must be updated. It turns that byte into a series of one-hot select vectors, one for each set bit. Each vector drives the byte-enable of a single write, and the consumer accepts one vector per clock by raising `advance`.

Bits are served from the most significant set position downward. A served bit is cleared from the internal register. The next lower set bit is isolated by a prefix-OR mask chain, and adjacent mask bits are XORed to form the select. When nothing remains, `done` rises. The register stays stable while the consumer stalls. A new byte is accepted only while `done` is high.

Top module: `vecSelSequencer`

## Requirements
- R1: After reset, `done` is 1, `selValid` is 0 and `selVec` is 0.
- R2: In the cycle after a load of a nonzero byte, `selValid` is 1 and `done` is 0. `selVec` is one-hot and equals the highest set bit of the byte, where bit i of `selVec` stands for bit i of the byte.
- R3: A clock edge with `advance` high while `selValid` is high clears the bit being served. The next cycle presents the next lower set bit.
- R4: The XOR of all vectors emitted for one byte equals the loaded byte. The number of vectors emitted equals the number of set bits in the byte.
- R5: `done` rises in the cycle after the last set bit is retired. `selVec` is 0 and `selValid` is 0 whenever `done` is 1.
- R6: Loading 0x00 emits no vector, and `done` stays 1.
- R7: A load strobe while `done` is 0 is ignored, and the sequence in progress continues unchanged.
- R8: While `advance` is low, `selVec` and the remaining bits stay unchanged.
- R9: `advance` while `done` is 1 has no effect: outputs stay at `done`=1 and `selVec`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadStrobe | input | 1 | Load `loadByte` (accepted only while done) |
| loadByte | input | WIDTH | Vector-address byte to sequence |
| advance | input | 1 | Consumer accepts the current select vector |
| selVec | output | WIDTH | One-hot select of the bit being served |
| selValid | output | 1 | `selVec` holds a vector to be consumed |
| done | output | 1 | No set bits remain |

## Verification
The hardest case to reach from the ports is a load strobe that arrives in the middle of a sequence, when the register still holds only part of the byte that was loaded. The bench loads a byte, retires some of its bits, and then pulses the strobe with a different byte. It then checks that the remaining vectors still follow the original remainder. Long stalls of the consumer and `advance` pulses while `done` is high are also driven on purpose, so that the hold and ignore paths are seen at the outputs.

// File: rtl/vecSeqPkg.sv
package vecSeqPkg;
  typedef struct packed {
    logic load;
    logic retire;
  } seqStrobe_t;
endpackage

// File: rtl/vecSeqCtrl.sv
module vecSeqCtrl
  import vecSeqPkg::*;
(
  input  logic       loadStrobe,
  input  logic       advance,
  input  logic       regEmpty,
  output seqStrobe_t strobes
);
  always_comb begin
    strobes.load   = loadStrobe & regEmpty;
    strobes.retire = advance & ~regEmpty;
  end
endmodule

// File: rtl/vecSeqDatapath.sv
module vecSeqDatapath
  import vecSeqPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobes,
  input  logic [WIDTH-1:0] loadByte,
  output logic [WIDTH-1:0] selVec,
  output logic             regEmpty
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] vecReg;
  logic [WIDTH-1:0] maskW;
  logic [WIDTH-1:0] selW;

  assign maskW[TOP] = vecReg[TOP];
  assign selW[TOP]  = maskW[TOP];

  genvar j;
  generate
    for (j = 0; j < TOP; j++) begin : gMask
      assign maskW[j] = vecReg[j] | maskW[j+1];
      assign selW[j]  = maskW[j] ^ maskW[j+1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg <= '0;
    end else if (strobes.load) begin
      vecReg <= loadByte;
    end else if (strobes.retire) begin
      vecReg <= vecReg & ~selW;
    end
  end

  assign regEmpty = ~|vecReg;
  assign selVec   = selW;
endmodule

// File: rtl/vecSelSequencer.sv
module vecSelSequencer
  import vecSeqPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStrobe,
  input  logic [WIDTH-1:0] loadByte,
  input  logic             advance,
  output logic [WIDTH-1:0] selVec,
  output logic             selValid,
  output logic             done
);
  seqStrobe_t strobes;
  logic       regEmpty;

  vecSeqCtrl uCtrl (
    .loadStrobe(loadStrobe),
    .advance   (advance),
    .regEmpty  (regEmpty),
    .strobes   (strobes)
  );

  vecSeqDatapath #(.WIDTH(WIDTH)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .loadByte(loadByte),
    .selVec  (selVec),
    .regEmpty(regEmpty)
  );

  assign done     = regEmpty;
  assign selValid = ~regEmpty;
endmodule

// File: rtl/vecSelSequencerChk.sv
module vecSelSequencerChk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadStrobe,
  input logic [WIDTH-1:0] loadByte,
  input logic             advance,
  input logic [WIDTH-1:0] selVec,
  input logic             selValid,
  input logic             done
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> $onehot(selVec)); // R2

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (selVec == '0 && !selValid)); // R5

  AST_RETIRE_DESCEND: assert property (@(posedge clk) disable iff (!rstN)
    (selValid && advance) |=> (done || (selVec < $past(selVec)))); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (selValid && !advance) |=> $stable(selVec)); // R8

  AST_BUSY_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (selValid && !advance && loadStrobe) |=> (selVec == $past(selVec))); // R7

  AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (done && loadStrobe && loadByte == '0) |=> done); // R6

  AST_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (done && advance && !loadStrobe) |=> done); // R9
endmodule

bind vecSelSequencer vecSelSequencerChk #(.WIDTH(WIDTH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .loadStrobe(loadStrobe),
  .loadByte  (loadByte),
  .advance   (advance),
  .selVec    (selVec),
  .selValid  (selValid),
  .done      (done)
);

// File: tb/tb_vecSelSequencer.sv
`timescale 1ns/1ps
module tb_vecSelSequencer;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadStrobe = 1'b0;
  logic [W-1:0] loadByte = '0;
  logic         advance = 1'b0;
  logic [W-1:0] selVec;
  logic         selValid;
  logic         done;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vecSelSequencer #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .loadByte(loadByte),
    .advance(advance), .selVec(selVec), .selValid(selValid), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] topBit(input logic [W-1:0] v);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) if (v[i]) r = '0 | (1 << i);
    return r;
  endfunction

  task automatic loadB(input logic [W-1:0] b);
    @(negedge clk);
    loadStrobe = 1'b1; loadByte = b;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  task automatic drainFrom(input logic [W-1:0] start, input logic [W-1:0] loaded,
                           input logic [W-1:0] xorIn, input int cntIn);
    logic [W-1:0] rem = start;
    logic [W-1:0] acc = xorIn;
    int cnt = cntIn;
    while (rem != '0) begin
      check(selVec == topBit(rem) && selValid && !done, "R2/R3 select", selVec, topBit(rem));
      acc ^= selVec;
      cnt++;
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
      rem &= ~topBit(rem);
    end
    check(done && !selValid && selVec == '0, "R5 done", selVec, '0);
    check(acc == loaded, "R4 xor", acc, loaded);
    check(cnt == $countones(loaded), "R4 count", W'(cnt), W'($countones(loaded)));
  endtask

  task automatic testPattern(input logic [W-1:0] b);
    loadB(b);
    drainFrom(b, b, '0, 0);
  endtask

  task automatic testZero();
    loadB('0);
    check(done && !selValid && selVec == '0, "R6 zero load", selVec, '0);
  endtask

  task automatic testStall();
    loadB(8'hA5);
    for (int k = 0; k < 5; k++) begin
      check(selVec == 8'h80 && selValid, "R8 stall hold", selVec, 8'h80);
      @(negedge clk);
    end
    drainFrom(8'hA5, 8'hA5, '0, 0);
  endtask

  task automatic testBusyLoad();
    logic [W-1:0] acc = '0;
    loadB(8'h6C);
    acc ^= selVec;
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    loadStrobe = 1'b1; loadByte = 8'h01;
    @(negedge clk);
    loadStrobe = 1'b0;
    check(selVec == 8'h20, "R7 busy load ignored", selVec, 8'h20);
    drainFrom(8'h2C, 8'h6C, acc, 1);
  endtask

  task automatic testIdleAdvance();
    @(negedge clk);
    advance = 1'b1;
    @(negedge clk);
    @(negedge clk);
    advance = 1'b0;
    check(done && !selValid && selVec == '0, "R9 idle advance", selVec, '0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%02h expected=%02h", selVec, 8'h00);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(done && !selValid && selVec == '0, "R1 reset", selVec, '0);
    testPattern(8'hFF);
    testPattern(8'h01);
    testPattern(8'h80);
    testPattern(8'h5A);
    testZero();
    testStall();
    testBusyLoad();
    testIdleAdvance();
    testPattern(8'h81);
    finishRun();
  end
endmodule